// File: doc/BRIEF.md
# Master/Slave Switching Clock Synchroniser

This block sets the switching period of a digital PWM controller and lets two controllers share one sync line. A counter of system clocks marks the start of each switching cycle with a one-clock strobe. While the block runs on its own, it drives a fixed-width pulse onto the shared line half a period after each of its own cycle starts. A controller that sees pulses on the line arriving faster than its own rate restarts its cycle on each of them and stops driving the line. As a result, when two controllers are tied together, the faster one becomes master and the slower one switches half a period behind it.

The period is programmed in system clocks. A value of zero selects the default period. Other values are clamped between the fastest allowed period and the default one. A new value takes effect at the next cycle start. The sync input is passed through a two-flop synchroniser and a rising-edge detector. Edges that echo the block's own pulse are ignored. An external edge restarts the counter only if the interval since the previous accepted edge is shorter than the block's own period. When such edges stop, the counter reaches its terminal count and the block falls back to running on its own.

With the default parameters and a 100 MHz clock, the default period is 400 clocks (250 kHz) and the fastest period is 100 clocks (1 MHz). The emitted pulse is 11 clocks wide (110 ns).

Top module: `swsync_top`

## Requirements
- R1: While reset is asserted and in the first cycle after it, cycleStart is 1, syncOut is 0, syncOe is 1 and locked is 0. The first cycle after reset lasts the default period of 400 clocks.
- R2: While free-running, cycleStart is high for exactly one clock every P clocks, where P is the effective period.
- R3: The effective period P is set by periodCfg as follows. The value 0 gives 400. Values from 1 to 99 give 100. Values above 400 give 400. Any other value is used as is. A new value applies from the cycle after the next cycle start.
- R4: While unlocked, syncOe is 1 and syncOut goes high exactly floor(P/2) clocks after a cycleStart and stays high for 11 clocks.
- R5: syncIn is sampled by two flops and then edge-detected. When an accepted edge restarts the period, cycleStart is high on the third clock edge after the first edge that samples syncIn high. It is not high on the second.
- R6: A rising edge on syncIn whose distance from the previous accepted edge is less than P clocks restarts the counter and sets locked to 1.
- R7: A rising edge whose distance from the previous accepted edge is P clocks or more does not restart the counter and leaves locked at 0. Free-running then continues with period P.
- R8: While locked is 1, syncOe is 0 and syncOut is 0.
- R9: When the counter reaches terminal count P-1 without a qualifying edge, it restarts, locked falls to 0 in that same clock, and free-running resumes with period P and half-period pulses.
- R10: Rising edges seen on syncIn within 14 clocks after the block starts its own pulse are ignored. The block's own pulse looped back onto syncIn therefore neither changes the period nor sets locked.
- R11: A syncIn pulse only one clock wide is accepted as an edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| periodCfg | input | 16 | Programmed period in system clocks (0 selects the default) |
| syncIn | input | 1 | Level seen on the shared sync line |
| cycleStart | output | 1 | One-clock strobe at the start of each switching cycle |
| syncOut | output | 1 | Half-period sync pulse to the shared line |
| syncOe | output | 1 | Drive enable for the shared line |
| locked | output | 1 | Cycle timing follows an external master |

## Verification
Most internal faults show at the ports within one switching period. A wrong counter or period register changes the spacing of cycleStart or the position of the half-period pulse in the very next cycle. A wrong interval counter or edge qualifier either locks onto a source that is too slow or fails to lock onto one that is only one clock faster. In both cases the lock flag and the output enable are wrong at the third clock after the edge. A broken self-echo guard makes a free-running block restart on its own pulse, which shortens the measured period to about half.

// File: rtl/swsync_pkg.sv
package swsync_pkg;

  // Strobes sent from the sequencing control to the counter datapath.
  typedef struct packed {
    logic restart;   // begin a new switching cycle on the next edge
    logic driveEn;   // this block owns the shared sync line
  } seqStrobe_t;

endpackage

// File: rtl/swsync_ctrl.sv
module swsync_ctrl
  import swsync_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int PULSE_CYC   = 11,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             syncIn,
  input  logic [CNT_W-1:0] periodReg,
  input  logic             atTerm,
  input  logic             pulseStart,
  output seqStrobe_t       strobeO,
  output logic             lockedO
);

  localparam int GUARD_CYC = PULSE_CYC + SYNC_STAGES + 1;
  localparam int GW        = $clog2(GUARD_CYC + 1);

  logic [SYNC_STAGES-1:0] syncChain;
  logic                   lineLast;
  logic                   extRise;
  logic                   guardActive;
  logic                   edgeSeen;
  logic                   edgeFast;
  logic [CNT_W-1:0]       sinceEdge;
  logic [GW-1:0]          guardCnt;
  logic                   lockedQ;

  // Synchroniser chain, one flop per stage.
  for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_sync
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncChain[g] <= 1'b0;
        else       syncChain[g] <= syncIn;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncChain[g] <= 1'b0;
        else       syncChain[g] <= syncChain[g-1];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) lineLast <= 1'b0;
    else       lineLast <= syncChain[SYNC_STAGES-1];
  end

  assign extRise     = syncChain[SYNC_STAGES-1] & ~lineLast;
  assign guardActive = (guardCnt != '0);
  assign edgeSeen    = extRise & ~guardActive;
  assign edgeFast    = edgeSeen & (sinceEdge < periodReg);

  // Clocks since the last accepted external edge, saturating.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 sinceEdge <= '1;
    else if (edgeSeen)         sinceEdge <= CNT_W'(1);
    else if (sinceEdge != '1)  sinceEdge <= sinceEdge + CNT_W'(1);
  end

  // Guard window that hides the echo of this block's own pulse.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                        guardCnt <= '0;
    else if (pulseStart && !lockedQ)  guardCnt <= GW'(GUARD_CYC);
    else if (guardActive)             guardCnt <= guardCnt - GW'(1);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                    lockedQ <= 1'b0;
    else if (edgeFast)            lockedQ <= 1'b1;
    else if (atTerm || edgeSeen)  lockedQ <= 1'b0;
  end

  assign strobeO.restart = edgeFast | atTerm;
  assign strobeO.driveEn = ~lockedQ;
  assign lockedO         = lockedQ;

  AST_LOCK_NEEDS_RESTART: assert property (@(posedge clk) disable iff (!rstN)
    $rose(lockedQ) |-> $past(strobeO.restart)); // R6

  AST_SLOW_EDGE_NO_LOCK: assert property (@(posedge clk) disable iff (!rstN)
    (edgeSeen && (sinceEdge >= periodReg)) |=> !lockedQ); // R7

  AST_GUARD_AFTER_OWN_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    (pulseStart && !lockedQ) |=> guardActive); // R10

endmodule

// File: rtl/swsync_dp.sv
module swsync_dp
  import swsync_pkg::*;
#(
  parameter int CNT_W      = 16,
  parameter int DEF_PERIOD = 400,
  parameter int MIN_PERIOD = 100,
  parameter int PULSE_CYC  = 11
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [CNT_W-1:0] periodCfg,
  input  seqStrobe_t       strobeI,
  output logic [CNT_W-1:0] periodReg,
  output logic             atTerm,
  output logic             pulseStart,
  output logic             cycleStart,
  output logic             syncOut,
  output logic             syncOe
);

  localparam int PW = $clog2(PULSE_CYC + 1);
  localparam logic [CNT_W-1:0] DEF_P = CNT_W'(DEF_PERIOD);
  localparam logic [CNT_W-1:0] MIN_P = CNT_W'(MIN_PERIOD);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] effPeriod;
  logic [CNT_W-1:0] halfPoint;
  logic [PW-1:0]    pulseLeft;
  logic             pulseOn;

  always_comb begin
    if (periodCfg == '0)        effPeriod = DEF_P;
    else if (periodCfg < MIN_P) effPeriod = MIN_P;
    else if (periodCfg > DEF_P) effPeriod = DEF_P;
    else                        effPeriod = periodCfg;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt       <= '0;
      periodReg <= DEF_P;
    end else if (strobeI.restart) begin
      cnt       <= '0;
      periodReg <= effPeriod;
    end else begin
      cnt       <= cnt + CNT_W'(1);
    end
  end

  assign halfPoint  = periodReg >> 1;
  assign pulseStart = (cnt == halfPoint);
  assign atTerm     = (cnt == periodReg - CNT_W'(1));
  assign cycleStart = (cnt == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                  pulseLeft <= '0;
    else if (pulseStart)        pulseLeft <= PW'(PULSE_CYC - 1);
    else if (pulseLeft != '0)   pulseLeft <= pulseLeft - PW'(1);
  end

  assign pulseOn = pulseStart | (pulseLeft != '0);
  assign syncOut = pulseOn & strobeI.driveEn;
  assign syncOe  = strobeI.driveEn;

  AST_CNT_BELOW_PERIOD: assert property (@(posedge clk) disable iff (!rstN)
    cnt < periodReg); // R2

  AST_PERIOD_CLAMPED: assert property (@(posedge clk) disable iff (!rstN)
    (periodReg >= MIN_P) && (periodReg <= DEF_P)); // R3

  AST_PULSE_HELD: assert property (@(posedge clk) disable iff (!rstN)
    $rose(pulseOn) |=> pulseOn); // R4

endmodule

// File: rtl/swsync_top.sv
module swsync_top
  import swsync_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int DEF_PERIOD  = 400,
  parameter int MIN_PERIOD  = 100,
  parameter int PULSE_CYC   = 11,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [CNT_W-1:0] periodCfg,
  input  logic             syncIn,
  output logic             cycleStart,
  output logic             syncOut,
  output logic             syncOe,
  output logic             locked
);

  seqStrobe_t       seqStrobe;
  logic [CNT_W-1:0] periodReg;
  logic             atTerm;
  logic             pulseStart;

  swsync_ctrl #(
    .CNT_W       (CNT_W),
    .PULSE_CYC   (PULSE_CYC),
    .SYNC_STAGES (SYNC_STAGES)
  ) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .syncIn     (syncIn),
    .periodReg  (periodReg),
    .atTerm     (atTerm),
    .pulseStart (pulseStart),
    .strobeO    (seqStrobe),
    .lockedO    (locked)
  );

  swsync_dp #(
    .CNT_W      (CNT_W),
    .DEF_PERIOD (DEF_PERIOD),
    .MIN_PERIOD (MIN_PERIOD),
    .PULSE_CYC  (PULSE_CYC)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .periodCfg  (periodCfg),
    .strobeI    (seqStrobe),
    .periodReg  (periodReg),
    .atTerm     (atTerm),
    .pulseStart (pulseStart),
    .cycleStart (cycleStart),
    .syncOut    (syncOut),
    .syncOe     (syncOe)
  );

  AST_START_SPACED: assert property (@(posedge clk) disable iff (!rstN)
    cycleStart |=> !cycleStart); // R2

  AST_SLAVE_SILENT: assert property (@(posedge clk) disable iff (!rstN)
    locked |-> (!syncOut && !syncOe)); // R8

endmodule

// File: tb/swsync_top_tb.sv
module swsync_top_tb;

  logic        clk = 1'b0;
  logic        rstN;
  logic [15:0] periodCfg;
  logic        extDrv;
  logic        syncLine;
  logic        cycleStart, syncOut, syncOe, locked;
  int          errs = 0;
  int          checks = 0;
  bit          done = 1'b0;
  int          expCur;

  always #5 clk = ~clk;

  // Shared line: own drive looped back, ORed with the external master.
  assign syncLine = (syncOe & syncOut) | extDrv;

  swsync_top u_dut (
    .clk        (clk),
    .rstN       (rstN),
    .periodCfg  (periodCfg),
    .syncIn     (syncLine),
    .cycleStart (cycleStart),
    .syncOut    (syncOut),
    .syncOe     (syncOe),
    .locked     (locked)
  );

  function automatic int effP(input int cfg);
    if (cfg == 0)   return 400;
    if (cfg < 100)  return 100;
    if (cfg > 400)  return 400;
    return cfg;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Starts at a negedge where cycleStart is 1; ends at the next such negedge.
  task automatic measureCycle(input int expP, input string req);
    int rise = -1, width = 0, n = 0, bad = 0;
    for (int i = 1; i <= 2000; i++) begin
      @(negedge clk);
      if (syncOut) begin
        if (rise < 0) rise = i;
        width++;
      end
      if (locked || !syncOe) bad++;
      if (cycleStart) begin
        n = i;
        break;
      end
    end
    chk(n == expP, {req, " period"}, n, expP);
    chk(rise == expP / 2, "R4 pulse position", rise, expP / 2);
    chk(width == 11, "R4 pulse width", width, 11);
    chk(bad == 0, "R10 no self lock", bad, 0);
  endtask

  task automatic waitStart();
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      if (cycleStart) break;
    end
  endtask

  task automatic lockTrial(input int pe, input int w, input bit expLock, input string req);
    int bad = 0;
    for (int k = 0; k < 10; k++) begin
      for (int i = 0; i < pe; i++) begin
        if (i != 0 || k != 0) @(negedge clk);
        if (k >= 8) begin
          if (expLock) begin
            if (i == 2) chk(!cycleStart, "R5 not early", cycleStart, 0);
            if (i == 3) begin
              chk(cycleStart, {req, " R5 aligned start"}, cycleStart, 1);
              chk(locked, {req, " R6 locked"}, locked, 1);
              chk(!syncOe, "R8 oe off", syncOe, 0);
            end
            if (syncOut) bad++;
          end else if (i == 3) begin
            chk(!locked, {req, " R7 stays unlocked"}, locked, 0);
            chk(syncOe, "R7 still drives", syncOe, 1);
          end
        end
        extDrv = (i < w);
      end
    end
    if (expLock) begin
      chk(bad == 0, "R8 silent while locked", bad, 0);
      for (int j = pe; j <= 403; j++) begin
        @(negedge clk);
        if (j == 402) chk(locked, "R9 held to terminal", locked, 1);
        if (j == 403) begin
          chk(cycleStart, "R9 terminal restart", cycleStart, 1);
          chk(!locked, "R9 lock lost", locked, 0);
          chk(syncOe, "R9 drive back", syncOe, 1);
        end
      end
      measureCycle(400, "R9");
    end else begin
      waitStart();
      measureCycle(400, "R7");
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errs++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    int dirVals[7] = '{250, 0, 37, 100, 401, 65535, 399};
    void'($urandom(32'd4242));
    rstN = 1'b0;
    periodCfg = 16'd0;
    extDrv = 1'b0;
    repeat (3) @(negedge clk);
    chk(cycleStart && !syncOut && syncOe && !locked, "R1 in reset", 0, 1);
    rstN = 1'b1;
    #1;
    chk(cycleStart, "R1 cycleStart", cycleStart, 1);
    chk(!syncOut, "R1 syncOut", syncOut, 0);
    chk(syncOe, "R1 syncOe", syncOe, 1);
    chk(!locked, "R1 locked", locked, 0);
    measureCycle(400, "R1 default");
    expCur = 400;
    // R3 directed values, then random ones
    foreach (dirVals[d]) begin
      periodCfg = 16'(dirVals[d]);
      measureCycle(expCur, "R3 directed");
      expCur = effP(dirVals[d]);
    end
    for (int r = 0; r < 6; r++) begin
      int v = $urandom_range(0, 700);
      periodCfg = 16'(v);
      measureCycle(expCur, "R2 random");
      expCur = effP(v);
    end
    measureCycle(expCur, "R3 last");
    periodCfg = 16'd400;
    measureCycle(expCur, "R2");
    expCur = 400;
    // Lock behaviour, each trial starting at a cycleStart
    lockTrial(399, 7, 1'b1, "R6 one faster");
    lockTrial(400, 7, 1'b0, "R7 equal");
    lockTrial(470, 7, 1'b0, "R7 slower");
    lockTrial(150, 1, 1'b1, "R11 short pulse");
    for (int t = 0; t < 2; t++) begin
      lockTrial($urandom_range(230, 390), $urandom_range(1, 7), 1'b1, "R6 random");
    end
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

endmodule